// File: doc/BRIEF.md
# Transmit Sample FIFO with DMA and Interrupt Control

This block holds outgoing audio samples between a bus-side write port and a serializer. Each write pushes one 32-bit sample. Each serializer read request pops the oldest sample, which is presented combinationally on `rd_data`. The current occupancy is reported on a 6-bit level output.

A DMA request is raised while the level sits at or below a programmable watermark. Two interrupt sources are kept: a level-sensitive "nearly empty" status and a sticky underrun status. Each source has an enable, and underrun is cleared by a write-one pulse. A full FIFO drops further writes and sets a sticky overflow flag.

A clear command runs a small state machine: IDLE → CLR_FIFO → SER_RST → SETTLE → IDLE. The FIFO is flushed at the end of CLR_FIFO. The serial-side reset strobe is driven during SER_RST. The busy indication drops back to zero by itself once the machine returns to IDLE. The transitions are:
- IDLE to CLR_FIFO on `clr_cmd`.
- CLR_FIFO to SER_RST, SER_RST to SETTLE, and SETTLE to IDLE, each unconditionally on the next clock.

Watermark and threshold fields are stored as the value minus one. A single clock is assumed.

Top module: `tx_sample_fifo`

## Requirements
- R1: `level` counts stored samples, 0 to 32. An accepted write adds one and an accepted read removes one. Samples leave in the order they were written, and `rd_data` shows the oldest sample in the cycle it is popped.
- R2: A write while `level` is 32 (and not busy) is dropped and sets `ovf_flag`. `ovf_flag` stays set until a clear command flushes the FIFO.
- R3: `dma_req` is 1 exactly when `dma_en` is 1, `clr_busy` is 0 and `level` is at most `dma_wmark_m1`+1. With `dma_en` at 0, `dma_req` is 0.
- R4: `sts_empty` is 1 exactly when `level` is at most `irq_thr_m1`, that is, below the threshold `irq_thr_m1`+1.
- R5: A read request while `level` is 0 and not busy sets the sticky `sts_undr`. A `undr_clr` pulse clears it on the next cycle. If a new underrun occurs in the same cycle as the clear, the set wins.
- R6: `irq` is the OR of (`sts_empty` AND `empty_ie`) and (`sts_undr` AND `undr_ie`).
- R7: `clr_cmd` seen in IDLE makes `clr_busy` 1 for exactly three cycles (CLR_FIFO, SER_RST, SETTLE) starting at the next clock edge, after which it returns to 0. `ser_rst` is 1 only in the SER_RST state, which is the second busy cycle. `clr_cmd` while busy is ignored.
- R8: From the second busy cycle on, `level` is 0 and `ovf_flag` is 0. While busy, writes and reads are ignored: no sample is stored, none is popped, and neither overflow nor underrun is flagged.
- R9: After reset, `level`, `clr_busy`, `ser_rst`, `sts_undr` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` this cycle |
| wr_data | input | 32 | Sample to store |
| rd_req | input | 1 | Serializer pops one sample this cycle |
| rd_data | output | 32 | Oldest stored sample |
| dma_en | input | 1 | Enables the DMA request |
| dma_wmark_m1 | input | 5 | DMA watermark minus one |
| irq_thr_m1 | input | 5 | Nearly-empty threshold minus one |
| empty_ie | input | 1 | Enable for the nearly-empty interrupt |
| undr_ie | input | 1 | Enable for the underrun interrupt |
| undr_clr | input | 1 | Write-one pulse clearing the underrun status |
| clr_cmd | input | 1 | Starts the flush sequence |
| clr_busy | output | 1 | Flush sequence in progress |
| ser_rst | output | 1 | Reset strobe for serial-side logic |
| level | output | 6 | Current fill level |
| dma_req | output | 1 | DMA request |
| sts_empty | output | 1 | Nearly-empty status |
| sts_undr | output | 1 | Sticky underrun status |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach are a completely full FIFO receiving yet another write, and a clear command that lands while writes and reads keep arriving. Random stimulus rarely fills all 32 entries on its own. The stimulus therefore runs directed phases that write without reading until past full, then read without writing until past empty. It also issues clear commands in the middle of busy traffic. Between the directed phases run random phases that swing between write-heavy and read-heavy biases with random watermark and threshold settings. A bench-side queue model predicts every output each cycle.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_CLR_FIFO = 2'd1,
        CS_SER_RST  = 2'd2,
        CS_SETTLE   = 2'd3
    } clr_state_t;

    localparam int unsigned N_IRQ_SRC = 2;
endpackage

// File: rtl/tfq_store.sv
module tfq_store #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= wptr + AW'(1);
            end
            if (pop) begin
                rptr <= rptr + AW'(1);
            end
            count <= count + LVL_W'(push) - LVL_W'(pop);
        end
    end

    assign rdata = mem[rptr];
    assign full  = (count == LVL_W'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/tfq_clr_ctrl.sv
module tfq_clr_ctrl
    import tfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_cmd,
    output logic busy,
    output logic flush,
    output logic ser_rst
);
    clr_state_t state_q;
    clr_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:     if (clr_cmd) state_d = CS_CLR_FIFO;
            CS_CLR_FIFO: state_d = CS_SER_RST;
            CS_SER_RST:  state_d = CS_SETTLE;
            CS_SETTLE:   state_d = CS_IDLE;
            default:     state_d = CS_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        flush   = 1'b0;
        ser_rst = 1'b0;
        unique case (state_q)
            CS_IDLE:     busy    = 1'b0;
            CS_CLR_FIFO: flush   = 1'b1;
            CS_SER_RST:  ser_rst = 1'b1;
            CS_SETTLE:   busy    = 1'b1;
            default:     busy    = 1'b1;
        endcase
    end
endmodule

// File: rtl/tfq_status.sv
module tfq_status
    import tfq_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned WM_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] count,
    input  logic             full,
    input  logic             empty,
    input  logic             busy,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_req,
    input  logic             dma_en,
    input  logic [WM_W-1:0]  dma_wmark_m1,
    input  logic [WM_W-1:0]  irq_thr_m1,
    input  logic             empty_ie,
    input  logic             undr_ie,
    input  logic             undr_clr,
    output logic             dma_req,
    output logic             sts_empty,
    output logic             sts_undr,
    output logic             ovf_flag,
    output logic             irq
);
    logic [LVL_W-1:0]     dma_limit;
    logic                 undr_hit;
    logic                 ovf_hit;
    logic [N_IRQ_SRC-1:0] src_sts;
    logic [N_IRQ_SRC-1:0] src_en;
    logic [N_IRQ_SRC-1:0] src_act;

    assign dma_limit = LVL_W'(dma_wmark_m1) + LVL_W'(1);
    assign dma_req   = dma_en && !busy && (count <= dma_limit);
    assign sts_empty = (count <= LVL_W'(irq_thr_m1));
    assign undr_hit  = rd_req && empty && !busy;
    assign ovf_hit   = wr_en && full && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_undr <= 1'b0;
        end else if (undr_hit) begin
            sts_undr <= 1'b1;
        end else if (undr_clr) begin
            sts_undr <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (flush) begin
            ovf_flag <= 1'b0;
        end else if (ovf_hit) begin
            ovf_flag <= 1'b1;
        end
    end

    assign src_sts = {sts_undr, sts_empty};
    assign src_en  = {undr_ie, empty_ie};

    for (genvar g = 0; g < N_IRQ_SRC; g++) begin : g_src
        assign src_act[g] = src_sts[g] & src_en[g];
    end

    assign irq = |src_act;
endmodule

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned WM_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dma_en,
    input  logic [WM_W-1:0]   dma_wmark_m1,
    input  logic [WM_W-1:0]   irq_thr_m1,
    input  logic              empty_ie,
    input  logic              undr_ie,
    input  logic              undr_clr,
    input  logic              clr_cmd,
    output logic              clr_busy,
    output logic              ser_rst,
    output logic [LVL_W-1:0]  level,
    output logic              dma_req,
    output logic              sts_empty,
    output logic              sts_undr,
    output logic              ovf_flag,
    output logic              irq
);
    logic flush;
    logic full;
    logic empty;
    logic push;
    logic pop;

    assign push = wr_en && !clr_busy && !full;
    assign pop  = rd_req && !clr_busy && !empty;

    tfq_clr_ctrl u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_cmd (clr_cmd),
        .busy    (clr_busy),
        .flush   (flush),
        .ser_rst (ser_rst)
    );

    tfq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .wdata (wr_data),
        .rdata (rd_data),
        .count (level),
        .full  (full),
        .empty (empty)
    );

    tfq_status #(.DEPTH(DEPTH)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (level),
        .full         (full),
        .empty        (empty),
        .busy         (clr_busy),
        .flush        (flush),
        .wr_en        (wr_en),
        .rd_req       (rd_req),
        .dma_en       (dma_en),
        .dma_wmark_m1 (dma_wmark_m1),
        .irq_thr_m1   (irq_thr_m1),
        .empty_ie     (empty_ie),
        .undr_ie      (undr_ie),
        .undr_clr     (undr_clr),
        .dma_req      (dma_req),
        .sts_empty    (sts_empty),
        .sts_undr     (sts_undr),
        .ovf_flag     (ovf_flag),
        .irq          (irq)
    );
endmodule

// File: rtl/tx_sample_fifo_chk.sv
module tx_sample_fifo_chk #(
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             dma_en,
    input logic             empty_ie,
    input logic             undr_ie,
    input logic             undr_clr,
    input logic             clr_busy,
    input logic             ser_rst,
    input logic [LVL_W-1:0] level,
    input logic             dma_req,
    input logic             sts_empty,
    input logic             sts_undr,
    input logic             ovf_flag,
    input logic             irq
);
    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R1
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !clr_busy |=> ovf_flag); // R2
    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req); // R3
    AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        level == '0 |-> sts_empty); // R4
    AST_UNDR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        undr_clr && !rd_req |=> !sts_undr); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_ie && !undr_ie |-> !irq); // R6
    AST_CLR_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_busy) |=> clr_busy ##1 clr_busy ##1 !clr_busy); // R7
    AST_SERRST_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rst |-> clr_busy); // R7
    AST_FLUSHED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy && $past(clr_busy) |-> level == '0 && !ovf_flag); // R8
endmodule

bind tx_sample_fifo tx_sample_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .dma_en    (dma_en),
    .empty_ie  (empty_ie),
    .undr_ie   (undr_ie),
    .undr_clr  (undr_clr),
    .clr_busy  (clr_busy),
    .ser_rst   (ser_rst),
    .level     (level),
    .dma_req   (dma_req),
    .sts_empty (sts_empty),
    .sts_undr  (sts_undr),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
);

// File: tb/tx_sample_fifo_test.sv
module tx_sample_fifo_test;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        dma_en = 1'b0;
    logic [4:0]  dma_wmark_m1 = '0;
    logic [4:0]  irq_thr_m1 = '0;
    logic        empty_ie = 1'b0;
    logic        undr_ie = 1'b0;
    logic        undr_clr = 1'b0;
    logic        clr_cmd = 1'b0;
    logic        clr_busy;
    logic        ser_rst;
    logic [5:0]  level;
    logic        dma_req;
    logic        sts_empty;
    logic        sts_undr;
    logic        ovf_flag;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] q[$];
    int  m_st = 0;
    bit  m_undr = 0;
    bit  m_ovf = 0;

    always #4 clk = ~clk;

    tx_sample_fifo uut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_dma(int lvl, bit busy);
        return dma_en && !busy && (lvl <= int'(dma_wmark_m1) + 1);
    endfunction

    function automatic bit exp_irq(bit se, bit su);
        return (se && empty_ie) || (su && undr_ie);
    endfunction

    task automatic step(input bit w, input logic [31:0] d, input bit r, input bit cc, input bit uc);
        int  lvl;
        bit  busy;
        bit  se;
        @(negedge clk);
        wr_en = w; wr_data = d; rd_req = r; clr_cmd = cc; undr_clr = uc;
        #1;
        lvl  = q.size();
        busy = (m_st != 0);
        se   = (lvl <= int'(irq_thr_m1));
        chk("R1", "level", 32'(level), 32'(lvl));
        chk("R2", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk("R3", "dma_req", 32'(dma_req), 32'(exp_dma(lvl, busy)));
        chk("R4", "sts_empty", 32'(sts_empty), 32'(se));
        chk("R5", "sts_undr", 32'(sts_undr), 32'(m_undr));
        chk("R6", "irq", 32'(irq), 32'(exp_irq(se, m_undr)));
        chk("R7", "clr_busy", 32'(clr_busy), 32'(busy));
        chk("R7", "ser_rst", 32'(ser_rst), 32'(m_st == 2));
        if (r && !busy && lvl > 0) chk("R1", "rd_data", rd_data, q[0]);
        if (busy && m_st >= 2) chk("R8", "level_busy", 32'(level), 32'd0);
        // model update for the coming edge
        if (r && !busy && lvl == 0) m_undr = 1;
        else if (uc) m_undr = 0;
        if (m_st == 1) begin
            q.delete();
            m_ovf = 0;
        end else if (!busy) begin
            if (w && lvl == DEPTH) m_ovf = 1;
            if (r && lvl > 0) void'(q.pop_front());
            if (w && lvl < DEPTH) q.push_back(d);
        end
        case (m_st)
            0: if (cc) m_st = 1;
            1: m_st = 2;
            2: m_st = 3;
            default: m_st = 0;
        endcase
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9", "level", 32'(level), 0);
        chk("R9", "clr_busy", 32'(clr_busy), 0);
        chk("R9", "ser_rst", 32'(ser_rst), 0);
        chk("R9", "sts_undr", 32'(sts_undr), 0);
        chk("R9", "ovf_flag", 32'(ovf_flag), 0);

        // directed: fill past full (R2), watermark and thresholds mid-range
        dma_en = 1; dma_wmark_m1 = 5'd7; irq_thr_m1 = 5'd3; empty_ie = 1; undr_ie = 1;
        for (int i = 0; i < DEPTH + 3; i++) step(1, 32'hA000_0000 + i, 0, 0, 0);
        // drain past empty (R1 order, R5 underrun)
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 1);   // R5: set wins over clear
        step(0, 0, 0, 0, 1);   // R5: clear
        step(0, 0, 0, 0, 0);
        // R3: dma disabled
        dma_en = 0;
        step(0, 0, 0, 0, 0);
        dma_en = 1;
        // R7/R8: clear during traffic, with overflow pending
        for (int i = 0; i < DEPTH + 1; i++) step(1, 32'hB000_0000 + i, 0, 0, 0);
        step(1, 32'hC0DE, 0, 1, 0);
        step(1, 32'hC0DF, 1, 1, 0);   // clr_cmd ignored while busy
        step(1, 32'hC0E0, 1, 0, 0);
        step(1, 32'hC0E1, 1, 0, 0);
        step(1, 32'hC0E2, 0, 0, 0);
        step(0, 0, 1, 0, 0);

        // random phases
        for (int ph = 0; ph < 40; ph++) begin
            int wbias = (ph % 2 == 0) ? 85 : 25;
            int rbias = (ph % 2 == 0) ? 20 : 80;
            dma_en       = ($urandom % 8) != 0;
            dma_wmark_m1 = 5'($urandom);
            irq_thr_m1   = 5'($urandom);
            empty_ie     = $urandom % 2;
            undr_ie      = $urandom % 2;
            for (int c = 0; c < 150; c++) begin
                step(($urandom % 100) < wbias, $urandom, ($urandom % 100) < rbias,
                     ($urandom % 200) == 0, ($urandom % 10) == 0);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule